// File: doc/BRIEF.md
# PCI Target Termination Classifier

This block watches a PCI bus from the initiator side and reports, for every data phase that the target ends, which kind of ending it was: an ordinary transfer, a disconnect that still moves data, a disconnect that moves none, a retry, or a target abort. It samples the active-low control lines FRAME#, IRDY#, TRDY#, STOP# and DEVSEL# on each rising clock edge. It produces a registered, one-clock result code and a running count of the data phases that have moved data in the current transaction.

A retry and a disconnect without data look the same on the wires. The block separates them by remembering whether any data phase has already completed in the transaction. It also enforces two target rules and raises a one-clock error pulse when either is broken. The first rule is that TRDY#, once asserted in a phase, stays asserted until that phase ends. The second is that STOP# and TRDY# are seen deasserted on the first idle clock after a transaction.

Top module: `pci_term_classifier`

## Requirements
- R1: While rst_n is low and on the first clock after it, result_o is 3'b000, count_o is 0 and both error outputs are 0.
- R2: A clock with FRAME# or IRDY# low is part of a transaction. If such a clock has IRDY#, TRDY# and DEVSEL# low and STOP# high, result_o is 3'b001 during the following clock only.
- R3: IRDY#, TRDY#, DEVSEL# and STOP# all low on a clock gives result_o 3'b010 on the next clock.
- R4: IRDY#, DEVSEL# and STOP# low with TRDY# high, after at least one completed phase in the same transaction, gives result_o 3'b011 on the next clock.
- R5: The same pattern as in R4, with no phase completed yet in the transaction, gives result_o 3'b100 on the next clock.
- R6: IRDY# and STOP# low with DEVSEL# high gives result_o 3'b101 on the next clock, and count_o does not change.
- R7: Only the first STOP#-based ending of a transaction is reported. Further STOP# clocks in that transaction give 3'b000.
- R8: A clock with IRDY# high, or with both FRAME# and IRDY# high (idle), gives 3'b000 whatever STOP#, TRDY# and DEVSEL# carry.
- R9: A phase completes on a clock with IRDY#, TRDY# and DEVSEL# all low, and each completion adds 1 to count_o on the next clock. count_o keeps its value through idle clocks and is cleared on the first clock of the next transaction.
- R10: count_o saturates at 2^CNT_W-1.
- R11: If TRDY# is low and IRDY# high on a transaction clock without STOP#, and TRDY# goes high on the next transaction clock, trdy_drop_err_o pulses for one clock.
- R12: On the first idle clock after a transaction, STOP# or TRDY# low makes release_err_o pulse for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | FRAME#, low while the initiator continues the transaction |
| irdy_n | input | 1 | IRDY#, initiator ready |
| trdy_n | input | 1 | TRDY#, target ready |
| stop_n | input | 1 | STOP#, target requests an end |
| devsel_n | input | 1 | DEVSEL#, target claimed the access |
| result_o | output | 3 | Termination code, valid for one clock |
| count_o | output | CNT_W | Completed data phases in the current or last transaction |
| trdy_drop_err_o | output | 1 | TRDY# released before its phase completed |
| release_err_o | output | 1 | STOP# or TRDY# low on the first idle clock |

## Verification
The bench builds the block with CNT_W = 3, so that saturation at 7 is reached after only a few phases. It sweeps all sixteen combinations of IRDY#, TRDY#, STOP# and DEVSEL#. Each combination is applied both as the first clock of a transaction and after one completed phase, which covers the retry versus disconnect split and every count update. Directed sequences then cover repeated STOP#, counter clearing and holding, saturation, and both release-rule violations.

// File: rtl/pci_term_pkg.sv
package pci_term_pkg;
    typedef enum logic [2:0] {
        TERM_NONE        = 3'b000,
        TERM_NORMAL      = 3'b001,
        TERM_DISC_DATA   = 3'b010,
        TERM_DISC_NODATA = 3'b011,
        TERM_RETRY       = 3'b100,
        TERM_ABORT       = 3'b101
    } term_e;
endpackage

// File: rtl/ptc_decode.sv
module ptc_decode
    import pci_term_pkg::*;
(
    input  logic  irdy,
    input  logic  trdy,
    input  logic  stop,
    input  logic  devsel,
    input  logic  moved,
    input  logic  term_done,
    output term_e cls,
    output logic  comp
);
    always_comb begin
        comp = irdy && trdy && devsel;
        cls  = TERM_NONE;
        if (irdy) begin
            if (stop) begin
                if (!term_done) begin
                    if (!devsel)
                        cls = TERM_ABORT;          // R6
                    else if (trdy)
                        cls = TERM_DISC_DATA;      // R3
                    else if (moved)
                        cls = TERM_DISC_NODATA;    // R4
                    else
                        cls = TERM_RETRY;          // R5
                end
            end else if (devsel && trdy) begin
                cls = TERM_NORMAL;                 // R2
            end
        end
    end
endmodule

// File: rtl/ptc_release_chk.sv
module ptc_release_chk (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic irdy,
    input  logic trdy,
    input  logic stop,
    output logic trdy_drop_err,
    output logic release_err
);
    typedef struct packed {
        logic was_active;
        logic pending;
        logic drop_err;
        logic rel_err;
    } chk_t;

    chk_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.was_active = active;
        st_d.pending    = active && trdy && !irdy && !stop;
        st_d.drop_err   = active && st_q.pending && !trdy;
        st_d.rel_err    = st_q.was_active && !active && (trdy || stop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trdy_drop_err = st_q.drop_err;
    assign release_err   = st_q.rel_err;

    assert_drop_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trdy_drop_err |=> !trdy_drop_err);
    assert_release_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        release_err |=> !release_err);
endmodule

// File: rtl/pci_term_classifier.sv
module pci_term_classifier
    import pci_term_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             stop_n,
    input  logic             devsel_n,
    output logic [2:0]       result_o,
    output logic [CNT_W-1:0] count_o,
    output logic             trdy_drop_err_o,
    output logic             release_err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             active;
        logic             moved;
        logic             term_done;
        logic [CNT_W-1:0] count;
        term_e            result;
    } state_t;

    state_t st_d, st_q;

    logic  active, start, moved_eff, comp;
    term_e cls;

    assign active    = !frame_n || !irdy_n;
    assign start     = active && !st_q.active;
    assign moved_eff = start ? 1'b0 : st_q.moved;

    ptc_decode u_decode (
        .irdy      (!irdy_n),
        .trdy      (!trdy_n),
        .stop      (!stop_n),
        .devsel    (!devsel_n),
        .moved     (moved_eff),
        .term_done (st_q.term_done && !start),
        .cls       (cls),
        .comp      (comp)
    );

    always_comb begin
        st_d        = st_q;
        st_d.active = active;
        st_d.result = active ? cls : TERM_NONE;          // R8
        if (!active) begin
            st_d.moved     = 1'b0;
            st_d.term_done = 1'b0;
        end else begin
            st_d.moved     = moved_eff || comp;
            st_d.term_done = (st_q.term_done && !start) ||
                             (cls != TERM_NONE && cls != TERM_NORMAL);
            if (start)
                st_d.count = comp ? CNT_W'(1) : '0;      // R9
            else if (comp && st_q.count != CNT_MAX)
                st_d.count = st_q.count + 1'b1;          // R10
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;                          // R1
        else        st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign count_o  = st_q.count;

    ptc_release_chk u_release (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .irdy          (!irdy_n),
        .trdy          (!trdy_n),
        .stop          (!stop_n),
        .trdy_drop_err (trdy_drop_err_o),
        .release_err   (release_err_o)
    );

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irdy_n |=> (result_o == 3'b000));
    assert_result_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        result_o <= 3'd5);
    assert_term_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o >= 3'd2) |=> (result_o < 3'd2));
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1 || count_o <= CNT_W'(1)));
    assert_count_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX) |=> (count_o == CNT_MAX || count_o <= CNT_W'(1)));
    assert_abort_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && !stop_n && devsel_n) |=> $stable(count_o) || count_o <= CNT_W'(1));
endmodule

// File: tb/pci_term_classifier_tb.sv
module pci_term_classifier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1, devsel_n = 1'b1;
    logic [2:0]    result_o;
    logic [CW-1:0] count_o;
    logic          trdy_drop_err_o, release_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_term_classifier #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n),
        .result_o(result_o), .count_o(count_o),
        .trdy_drop_err_o(trdy_drop_err_o), .release_err_o(release_err_o));

    // arguments are active-high: 1 means the line is driven low
    task automatic drive(input bit f, input bit i, input bit t, input bit s, input bit d);
        frame_n = !f; irdy_n = !i; trdy_n = !t; stop_n = !s; devsel_n = !d;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int model(bit i, bit t, bit s, bit d, bit moved);
        if (!i) return 0;
        if (s && !d) return 5;
        if (s && t) return 2;
        if (s) return moved ? 3 : 4;
        if (d && t) return 1;
        return 0;
    endfunction

    function automatic string tag(int e);
        case (e)
            1: return "R2 normal";
            2: return "R3 disc-data";
            3: return "R4 disc-nodata";
            4: return "R5 retry";
            5: return "R6 abort";
            default: return "R8 none";
        endcase
    endfunction

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        drive(0, 0, 0, 0, 0);
        step(); step();
        chk("R1 result in reset", result_o, 0);
        chk("R1 count in reset", count_o, 0);
        rst_n = 1'b1;
        step();
        chk("R1 result after reset", result_o, 0);
        chk("R1 count after reset", count_o, 0);
        chk("R1 drop err after reset", trdy_drop_err_o, 0);
        chk("R1 release err after reset", release_err_o, 0);

        // Sweep every line combination, with and without earlier data.
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 16; v++) begin
                bit i, t, s, d;
                int e, c;
                i = v[3]; t = v[2]; s = v[1]; d = v[0];
                drive(0, 0, 0, 0, 0); step();
                if (m == 1) begin
                    drive(1, 1, 1, 0, 1); step();
                    chk("R2 lead phase", result_o, 1);
                end
                drive(1, i, t, s, d); step();
                e = model(i, t, s, d, m == 1);
                c = m + ((i && t && d) ? 1 : 0);
                chk(tag(e), result_o, e);
                chk("R9 count after pattern", count_o, c);
                chk("R11 no drop err in sweep", trdy_drop_err_o, 0);
                drive(0, 0, 0, 0, 0); step();
                chk("R8 idle result", result_o, 0);
                chk("R12 clean release", release_err_o, 0);
                chk("R9 count held idle", count_o, c);
            end
        end

        // R7: STOP# held for several clocks reports once
        drive(0, 0, 0, 0, 0); step();
        drive(1, 1, 0, 1, 1); step();
        chk("R7 first stop is retry (R5)", result_o, 4);
        step();
        chk("R7 repeated stop silent", result_o, 0);
        drive(0, 1, 0, 1, 1); step();
        chk("R7 repeated stop silent again", result_o, 0);
        drive(0, 0, 0, 0, 0); step();

        // R9: clear at start of a new transaction, hold through idle
        for (int k = 0; k < 3; k++) begin drive(1, 1, 1, 0, 1); step(); end
        chk("R9 three phases", count_o, 3);
        drive(0, 0, 0, 0, 0); step(); step();
        chk("R9 held across idle", count_o, 3);
        drive(1, 0, 0, 0, 1); step();
        chk("R9 cleared on start", count_o, 0);
        drive(0, 0, 0, 0, 0); step();

        // R10: saturation
        for (int k = 0; k < 9; k++) begin drive(1, 1, 1, 0, 1); step(); end
        chk("R10 saturated", count_o, 7);
        chk("R2 result during burst", result_o, 1);
        drive(0, 0, 0, 0, 0); step();
        chk("R2 one clock pulse ends", result_o, 0);

        // R11: TRDY# dropped early
        drive(1, 0, 1, 0, 1); step();
        chk("R11 no error while waiting", trdy_drop_err_o, 0);
        drive(1, 0, 0, 0, 1); step();
        chk("R11 drop flagged", trdy_drop_err_o, 1);
        drive(1, 1, 1, 0, 1); step();
        chk("R11 pulse cleared", trdy_drop_err_o, 0);
        drive(0, 0, 0, 0, 0); step();

        // R12: STOP# low on first idle clock
        drive(1, 1, 1, 0, 1); step();
        drive(0, 1, 1, 0, 1); step();
        drive(0, 0, 0, 1, 0); step();
        chk("R12 release violation", release_err_o, 1);
        chk("R8 stop ignored while idle", result_o, 0);
        drive(0, 0, 0, 0, 0); step();
        chk("R12 pulse cleared", release_err_o, 0);

        // R12: TRDY# low on first idle clock
        drive(1, 1, 1, 0, 1); step();
        drive(0, 1, 1, 0, 1); step();
        drive(0, 0, 1, 0, 1); step();
        chk("R12 trdy release violation", release_err_o, 1);
        chk("R8 trdy ignored while idle", result_o, 0);
        drive(0, 0, 0, 0, 0); step();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule